// File: doc/BRIEF.md
# Shared Mailbox Bank with Level Interrupts

This block holds a small set of single-word mailboxes that two agents use to pass 31-bit messages. The sender writes a word with the top bit set. That stores the payload and marks the slot occupied. The receiver reads the word, then writes zero to release the slot. Each slot raises two level conditions: "occupied" while bit 31 of its word is set, and "vacant" while it is clear. The condition bits are packed into one status word. Each interrupt output has its own mask register, so software can route any condition to any line.

A read-only sizing word reports the bank's configuration. It gives the mailbox count, two further unit counts, a doorbell count and the interrupt line count, each as a 4-bit field. An optional per-mailbox pair of enables can suppress one slot's occupied or vacant condition before it reaches the status word. The parameter `PER_MB_IE` selects this option. All access goes through a plain register bus with a registered read path.

Top module: `hsp_mbox_bank`

## Requirements
- R1: After reset, every mailbox word reads 0, every line mask reads 0, and every interrupt output is low.
- R2: A write to a mailbox data register (window offset 0x0) stores all 32 bits. When bit 31 is set, the slot's occupied bit (status bit 8+i) becomes 1 and its vacant bit (status bit i) becomes 0. When bit 31 is clear, the slot stays vacant and the payload still reads back.
- R3: Writing zero to a mailbox data register clears both the payload and the occupied flag, and sets the slot's vacant status bit again.
- R4: The status word at 0x304 carries the vacant conditions in bits 7:0 and the occupied conditions in bits 15:8. Bits 31:16, and the bits for indices at or above the mailbox count, read 0.
- R5: Both conditions are levels. A vacant slot keeps an unmasked line high for as long as it stays vacant. The line drops only when the mask bit is cleared or the slot fills.
- R6: Line n has a 16-bit mask at 0x100+4*n that reads back as written. The line output equals the OR of (status AND mask). It is registered, so it is due one clock after the write that changes the status or the mask.
- R7: The sizing word at 0x380 holds: mailbox count in bits 3:0, first extra unit count in bits 7:4, second extra unit count in bits 11:8, doorbell count in bits 15:12, and line count in bits 19:16. Writes to it have no effect.
- R8: With `PER_MB_IE`=1, window offset 0x4 (occupied enable) and window offset 0x8 (vacant enable) hold one bit each, in bit 0. Both reset to 1 and read back. A 0 removes that slot's condition from the status word.
- R9: Writing a slot that is already occupied replaces the payload. The flag takes the new value of bit 31, and no error is raised.
- R10: Read data appears one clock after the address. Mailbox i's window starts at `MB_BASE` + i*2^`MB_STRIDE_LOG2`. Unmapped addresses, including masks of lines that do not exist, read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq_out | output | NUM_LINES | Level interrupt lines, registered |

## Verification
A write takes effect on the clock edge that samples it. Status is a combinational view of the stored state, so a status read issued on the next cycle returns the new value one edge later. An interrupt line changes one edge after the write that alters its status or mask. The bench drives on falling edges and samples on falling edges. It checks each line in the half-cycle just after the write, where the old value must still show, and again one cycle later, where the new value must show. Reads are checked one full cycle after the address is presented.

// File: rtl/hsp_mbox_pkg.sv
package hsp_mbox_pkg;
  localparam logic [15:0] OFS_LINE_MASK = 16'h0100;
  localparam logic [15:0] OFS_STATUS    = 16'h0304;
  localparam logic [15:0] OFS_SIZING    = 16'h0380;
  localparam logic [3:0]  WIN_DATA      = 4'h0;
  localparam logic [3:0]  WIN_FULL_EN   = 4'h4;
  localparam logic [3:0]  WIN_EMPTY_EN  = 4'h8;
  localparam int          FLAG_BIT      = 31;
  localparam int          FIELD_W       = 8;
  localparam int          STAT_W        = 2 * FIELD_W;

  typedef struct packed {
    logic occupied;
    logic vacant;
  } slot_cond_t;
endpackage

// File: rtl/hsp_mbox_slot.sv
module hsp_mbox_slot
  import hsp_mbox_pkg::*;
#(
  parameter int PER_MB_IE = 1,
  parameter int OFS_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] ofs,
  input  logic [31:0]      wdata,
  output logic [31:0]      rd_word,
  output slot_cond_t       cond,
  output logic             flag
);
  logic [31:0] word_q;
  logic        occ_en;
  logic        vac_en;

  always_ff @(posedge clk) begin
    if (rst) word_q <= '0;
    else if (wr_en && ofs == OFS_W'(WIN_DATA)) word_q <= wdata;
  end

  generate
    if (PER_MB_IE != 0) begin : g_local_en
      logic occ_en_q, vac_en_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          occ_en_q <= 1'b1;
          vac_en_q <= 1'b1;
        end else if (wr_en) begin
          if (ofs == OFS_W'(WIN_FULL_EN))  occ_en_q <= wdata[0];
          if (ofs == OFS_W'(WIN_EMPTY_EN)) vac_en_q <= wdata[0];
        end
      end
      assign occ_en = occ_en_q;
      assign vac_en = vac_en_q;
    end else begin : g_no_local_en
      assign occ_en = 1'b1;
      assign vac_en = 1'b1;
    end
  endgenerate

  always_comb begin
    rd_word = '0;
    if (ofs == OFS_W'(WIN_DATA)) rd_word = word_q;
    else if (PER_MB_IE != 0 && ofs == OFS_W'(WIN_FULL_EN))  rd_word = {31'b0, occ_en};
    else if (PER_MB_IE != 0 && ofs == OFS_W'(WIN_EMPTY_EN)) rd_word = {31'b0, vac_en};
  end

  assign flag          = word_q[FLAG_BIT];
  assign cond.occupied = word_q[FLAG_BIT] & occ_en;
  assign cond.vacant   = ~word_q[FLAG_BIT] & vac_en;
endmodule

// File: rtl/hsp_irq_line.sv
module hsp_irq_line
  import hsp_mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wdata,
  input  logic [STAT_W-1:0] status,
  output logic [STAT_W-1:0] mask,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '0;
      irq  <= 1'b0;
    end else begin
      if (wr_en) mask <= wdata;
      irq <= |(status & mask);
    end
  end
endmodule

// File: rtl/hsp_mbox_bank.sv
module hsp_mbox_bank
  import hsp_mbox_pkg::*;
#(
  parameter int NUM_MB         = 4,
  parameter int NUM_LINES      = 2,
  parameter int NUM_SS         = 2,
  parameter int NUM_AS         = 1,
  parameter int NUM_DB         = 3,
  parameter int PER_MB_IE      = 1,
  parameter int ADDR_W         = 16,
  parameter int MB_BASE        = 'h1000,
  parameter int MB_STRIDE_LOG2 = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_LINES-1:0] irq_out
);
  localparam int PAGE_W = ADDR_W - MB_STRIDE_LOG2;
  localparam int IDX_W  = (NUM_MB > 1) ? $clog2(NUM_MB) : 1;
  localparam int LIDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam logic [PAGE_W-1:0] BASE_PAGE = PAGE_W'(MB_BASE >> MB_STRIDE_LOG2);
  localparam logic [31:0] SIZING_WORD = {12'b0, 4'(NUM_LINES), 4'(NUM_DB),
                                         4'(NUM_AS), 4'(NUM_SS), 4'(NUM_MB)};

  logic [PAGE_W-1:0]   rel_page;
  logic                in_win;
  logic [IDX_W-1:0]    mb_idx;
  logic [ADDR_W-1:0]   line_rel;
  logic                line_hit;
  logic [LIDX_W-1:0]   line_idx;
  logic [31:0]         slot_rd [NUM_MB];
  slot_cond_t          cond    [NUM_MB];
  logic [NUM_MB-1:0]   mb_full;
  logic [STAT_W-1:0]   status;
  logic [NUM_LINES-1:0][STAT_W-1:0] line_mask;
  logic [31:0]         rd_next;

  assign rel_page = bus_addr[ADDR_W-1:MB_STRIDE_LOG2] - BASE_PAGE;
  assign in_win   = rel_page < PAGE_W'(NUM_MB);
  assign mb_idx   = rel_page[IDX_W-1:0];
  assign line_rel = bus_addr - ADDR_W'(OFS_LINE_MASK);
  assign line_hit = (bus_addr >= ADDR_W'(OFS_LINE_MASK)) && (line_rel[1:0] == 2'b00) &&
                    (line_rel[ADDR_W-1:2] < (ADDR_W-2)'(NUM_LINES));
  assign line_idx = line_rel[LIDX_W+1:2];

  generate
    for (genvar i = 0; i < NUM_MB; i++) begin : g_slot
      hsp_mbox_slot #(.PER_MB_IE(PER_MB_IE), .OFS_W(MB_STRIDE_LOG2)) u_slot (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_we && rel_page == PAGE_W'(i)),
        .ofs     (bus_addr[MB_STRIDE_LOG2-1:0]),
        .wdata   (bus_wdata),
        .rd_word (slot_rd[i]),
        .cond    (cond[i]),
        .flag    (mb_full[i])
      );
    end

    for (genvar b = 0; b < FIELD_W; b++) begin : g_status
      if (b < NUM_MB) begin : g_impl
        assign status[b]           = cond[b].vacant;
        assign status[FIELD_W + b] = cond[b].occupied;
      end else begin : g_unimpl
        assign status[b]           = 1'b0;
        assign status[FIELD_W + b] = 1'b0;
      end
    end

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
      hsp_irq_line u_line (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (bus_we && line_hit && line_idx == LIDX_W'(n)),
        .wdata  (bus_wdata[STAT_W-1:0]),
        .status (status),
        .mask   (line_mask[n]),
        .irq    (irq_out[n])
      );
    end
  endgenerate

  always_comb begin
    rd_next = '0;
    if (in_win)                                rd_next = slot_rd[mb_idx];
    else if (bus_addr == ADDR_W'(OFS_STATUS))  rd_next = {{(32-STAT_W){1'b0}}, status};
    else if (bus_addr == ADDR_W'(OFS_SIZING))  rd_next = SIZING_WORD;
    else if (line_hit)                         rd_next = {{(32-STAT_W){1'b0}}, line_mask[line_idx]};
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end
endmodule

// File: rtl/hsp_mbox_bank_chk.sv
module hsp_mbox_bank_chk
  import hsp_mbox_pkg::*;
#(
  parameter int NUM_MB         = 4,
  parameter int NUM_LINES      = 2,
  parameter int ADDR_W         = 16,
  parameter int MB_BASE        = 'h1000,
  parameter int MB_STRIDE_LOG2 = 8,
  parameter logic [31:0] SIZING_VAL = '0
) (
  input logic                 clk,
  input logic                 rst,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_we,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          bus_rdata,
  input logic [NUM_LINES-1:0] irq_out,
  input logic [STAT_W-1:0]    status,
  input logic [NUM_MB-1:0]    mb_full,
  input logic [NUM_LINES-1:0][STAT_W-1:0] line_mask
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (irq_out == '0 && bus_rdata == '0)); // R1

  AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_addr) == ADDR_W'(OFS_STATUS)) |-> bus_rdata[31:STAT_W] == '0); // R4

  AST_SIZING_FIXED: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_addr) == ADDR_W'(OFS_SIZING)) |-> bus_rdata == SIZING_VAL); // R7

  generate
    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line_chk
      AST_LINE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> irq_out[n] == |($past(status) & $past(line_mask[n]))); // R6
    end
    for (genvar i = 0; i < NUM_MB; i++) begin : g_mb_chk
      localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(MB_BASE + (i << MB_STRIDE_LOG2));
      AST_POST_SETS_FULL: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == DATA_ADDR && bus_wdata[31]) |=> mb_full[i]); // R2
      AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == DATA_ADDR && bus_wdata == '0) |=> !mb_full[i]); // R3
      AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_addr == DATA_ADDR) |=> $stable(mb_full[i])); // R5
    end
  endgenerate
endmodule

bind hsp_mbox_bank hsp_mbox_bank_chk #(
  .NUM_MB(NUM_MB), .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .MB_BASE(MB_BASE),
  .MB_STRIDE_LOG2(MB_STRIDE_LOG2), .SIZING_VAL(SIZING_WORD)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .irq_out(irq_out), .status(status), .mb_full(mb_full),
  .line_mask(line_mask)
);

// File: tb/hsp_mbox_bank_tb.sv
module hsp_mbox_bank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq_out;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hsp_mbox_bank u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  // {is_read, address, data-or-expected}
  localparam int NVEC = 29;
  localparam logic [48:0] VEC [NVEC] = '{
    {1'b1, 16'h0304, 32'h0000000F},  // R4 all vacant
    {1'b0, 16'h1100, 32'h80000055},  // R2 post mb1
    {1'b1, 16'h1100, 32'h80000055},  // R2
    {1'b1, 16'h0304, 32'h0000020D},  // R2 R4
    {1'b0, 16'h1100, 32'h800000AA},  // R9 overwrite
    {1'b1, 16'h1100, 32'h800000AA},  // R9
    {1'b1, 16'h0304, 32'h0000020D},  // R9
    {1'b0, 16'h1100, 32'h00000000},  // R3 release
    {1'b1, 16'h1100, 32'h00000000},  // R3
    {1'b1, 16'h0304, 32'h0000000F},  // R3
    {1'b0, 16'h0100, 32'hFFFFFFFF},  // R6 mask
    {1'b1, 16'h0100, 32'h0000FFFF},  // R6 readback
    {1'b0, 16'h0100, 32'h00000000},  // R6
    {1'b0, 16'h0380, 32'hFFFFFFFF},  // R7 ignored write
    {1'b1, 16'h0380, 32'h00023124},  // R7
    {1'b0, 16'h1008, 32'h00000000},  // R8 vacant enable off mb0
    {1'b1, 16'h1008, 32'h00000000},  // R8
    {1'b1, 16'h0304, 32'h0000000E},  // R8
    {1'b0, 16'h1008, 32'h00000001},  // R8
    {1'b0, 16'h1304, 32'h00000000},  // R8 occupied enable off mb3
    {1'b0, 16'h1300, 32'h80000001},  // R8
    {1'b1, 16'h0304, 32'h00000007},  // R8
    {1'b0, 16'h1300, 32'h00000000},  // R8
    {1'b0, 16'h1304, 32'h00000001},  // R8
    {1'b1, 16'h2000, 32'h00000000},  // R10 unmapped
    {1'b0, 16'h1000, 32'h00000007},  // R2 flag clear
    {1'b1, 16'h1000, 32'h00000007},  // R2
    {1'b1, 16'h0304, 32'h0000000F},  // R2
    {1'b0, 16'h1000, 32'h00000000}   // R3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 irq", {30'b0, irq_out}, 32'h0);
    rd(16'h1000, r); check("R1 mailbox word", r, 32'h0);
    rd(16'h0100, r); check("R1 line mask", r, 32'h0);

    for (int k = 0; k < NVEC; k++) begin
      if (VEC[k][48]) begin
        rd(VEC[k][47:32], r);
        check($sformatf("vector %0d", k), r, VEC[k][31:0]);
      end else begin
        wr(VEC[k][47:32], VEC[k][31:0]);
      end
    end

    // R6 latency and R5 level on line 1 for mb0 vacant
    wr(16'h0104, 32'h0000_0001);
    check("R6 line not yet high", {31'b0, irq_out[1]}, 32'h0);
    @(negedge clk);
    check("R6 line high one cycle later", {31'b0, irq_out[1]}, 32'h1);
    repeat (5) @(negedge clk);
    check("R5 line still high while vacant", {31'b0, irq_out[1]}, 32'h1);
    check("R6 other line low", {31'b0, irq_out[0]}, 32'h0);
    wr(16'h1000, 32'h8000_0001);
    @(negedge clk);
    check("R5 line drops when slot fills", {31'b0, irq_out[1]}, 32'h0);
    wr(16'h1000, 32'h0);
    @(negedge clk);
    check("R5 line returns when vacant", {31'b0, irq_out[1]}, 32'h1);
    wr(16'h0104, 32'h0);
    @(negedge clk);
    check("R5 masking drops line", {31'b0, irq_out[1]}, 32'h0);

    // R2/R3 on line 0 for mb0 occupied
    wr(16'h0100, 32'h0000_0100);
    @(negedge clk);
    check("R2 line0 idle", {31'b0, irq_out[0]}, 32'h0);
    wr(16'h1000, 32'h8000_0009);
    @(negedge clk);
    check("R2 occupied raises line0", {31'b0, irq_out[0]}, 32'h1);
    rd(16'h1000, r); check("R2 payload", r, 32'h8000_0009);
    wr(16'h1000, 32'h0);
    @(negedge clk);
    check("R3 release drops line0", {31'b0, irq_out[0]}, 32'h0);
    wr(16'h0100, 32'h0);

    // R10 nonexistent line mask
    wr(16'h0108, 32'h0000_FFFF);
    rd(16'h0108, r); check("R10 missing line reads zero", r, 32'h0);
    check("R10 lines unaffected", {30'b0, irq_out}, 32'h0);

    // R1 reset mid-run
    wr(16'h1100, 32'h8000_0077);
    wr(16'h0100, 32'h0000_0F0F);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 irq after reset", {30'b0, irq_out}, 32'h0);
    rd(16'h1100, r); check("R1 slot cleared", r, 32'h0);
    rd(16'h0100, r); check("R1 mask cleared", r, 32'h0);

    done = 1;
    summary();
  end
endmodule